// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Register

This block turns a serial bit stream into a bank of parallel outputs. Each device in the chain has two parts. A shift stage takes one bit per shift strobe. A storage stage copies the whole shift stage when a latch strobe arrives. Because the outputs come from the storage stage, a new word can be shifted in while the outputs keep showing the old one. The new word reaches the outputs in one step when the latch strobe arrives. A typical use is to let an SPI-style controller drive many static control lines through a few wires.

Several devices are chained in a generate loop. The last shift stage of each device feeds the first stage of the next device. The serial output of the last device is brought out so the chain can be extended off-block. The shift and storage sides are independent of each other:

- The shift clear acts on the shift stages only.
- The output enable controls only the drive enables of the parallel outputs. The serial output is always driven.

The two strobes are clock enables sampled on one system clock. Each high-impedance output is modelled as a data bit plus an enable bit.

Top module: `sreg_chain`

## Requirements
- R1: On a clock edge with `shift_en` high, `ser_in` enters stage 0 of device 0 and every stage i moves to stage i+1 of the same device. Device k's stage i appears at `par_q[k*WIDTH+i]` after latching.
- R2: On a clock edge with `latch_en` high, the storage stages of all devices take the values their shift stages held before that edge, all bits at once.
- R3: While `sr_clr_n` is low, every shift stage reads zero; the clear acts without waiting for a clock edge, and the storage stages keep their contents. A shift strobe sampled at either of the first two clock edges after `sr_clr_n` returns high is discarded.
- R4: With `oe_n` low, every bit of `par_oe` is 1; with `oe_n` high, every bit of `par_oe` is 0. In both cases `par_q` shows the storage contents, not inverted.
- R5: `ser_out` always shows stage WIDTH-1 of the last device, and `oe_n` has no effect on it.
- R6: On an edge without `shift_en`, the shift stages hold; on an edge without `latch_en`, the storage stages hold.
- R7: `par_q` changes only at an edge with `latch_en` high (or reset); shifting alone never alters it.
- R8: When `shift_en` and `latch_en` are high on the same edge, storage captures the pre-shift contents, so the outputs lag the shift stages by one position.
- R9: Stage WIDTH-1 of device k feeds stage 0 of device k+1 on each shift, so the chain acts as one NUM_DEV*WIDTH-stage register.
- R10: `rst_n` low clears the shift and storage stages to zero, acting without waiting for a clock edge. A latch strobe or shift strobe sampled at either of the first two clock edges after `rst_n` returns high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset, asynchronous assert |
| ser_in | input | 1 | Serial data into stage 0 of device 0 |
| shift_en | input | 1 | Shift strobe, sampled each clock edge |
| latch_en | input | 1 | Transfer strobe, shift to storage |
| sr_clr_n | input | 1 | Active-low clear of the shift stages only |
| oe_n | input | 1 | Active-low parallel output enable |
| par_q | output | NUM_DEV*WIDTH | Parallel data from the storage stages |
| par_oe | output | NUM_DEV*WIDTH | Per-bit drive enable for par_q |
| ser_out | output | 1 | Last stage of the last device |

## Verification
A wrong bit in any shift stage shows at `ser_out` after at most NUM_DEV*WIDTH further shifts. It also shows on `par_q` at the next latch strobe. A storage fault shows on `par_q` in the cycle right after the edge that caused it. Because the parallel outputs only move on latch strobes, a fault that touches storage when no latch strobe is present shows at once as a change on `par_q`. A wrong clear or reset release time shows as a missing or extra shifted bit, which later reaches `ser_out`.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  // Defaults shared by the chain and its cells.
  localparam int unsigned SREG_WIDTH_DEF = 8;
  localparam int unsigned SREG_DEVS_DEF  = 2;
  // Flops in each reset release synchronizer.
  localparam int unsigned SREG_SYNC_DEPTH = 2;
endpackage

// File: rtl/sreg_rst_sync.sv
`timescale 1ns/1ps
module sreg_rst_sync #(
  parameter int unsigned DEPTH = sreg_pkg::SREG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[DEPTH-1];
endmodule

// File: rtl/sreg_shift_stage.sv
`timescale 1ns/1ps
module sreg_shift_stage #(
  parameter int unsigned WIDTH = sreg_pkg::SREG_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] sr_o
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WIDTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q == {$past(sr_q[WIDTH-2:0]), $past(din)}));

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));

  // R3
  shift_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (sr_q == '0));
endmodule

// File: rtl/sreg_store_stage.sv
`timescale 1ns/1ps
module sreg_store_stage #(
  parameter int unsigned WIDTH = sreg_pkg::SREG_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] sr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] st_d;

  always_comb begin
    st_d = st_q;
    if (latch_en) st_d = sr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q;

  // R2
  store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> (st_q == $past(sr_i)));

  // R7
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(st_q));

  // R10
  store_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (st_q == '0));
endmodule

// File: rtl/sreg_cell.sv
`timescale 1ns/1ps
module sreg_cell #(
  parameter int unsigned WIDTH = sreg_pkg::SREG_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             sr_rst_n,
  input  logic             st_rst_n,
  input  logic             shift_en,
  input  logic             latch_en,
  input  logic             din,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_oe,
  output logic             dout
);
  logic [WIDTH-1:0] sr_bits;

  sreg_shift_stage #(.WIDTH(WIDTH)) shift_i (
    .clk      (clk),
    .rst_n    (sr_rst_n),
    .shift_en (shift_en),
    .din      (din),
    .sr_o     (sr_bits)
  );

  sreg_store_stage #(.WIDTH(WIDTH)) store_i (
    .clk      (clk),
    .rst_n    (st_rst_n),
    .latch_en (latch_en),
    .sr_i     (sr_bits),
    .q_o      (par_q)
  );

  assign par_oe = {WIDTH{~oe_n}};
  assign dout   = sr_bits[WIDTH-1];
endmodule

// File: rtl/sreg_chain.sv
`timescale 1ns/1ps
module sreg_chain #(
  parameter int unsigned WIDTH   = sreg_pkg::SREG_WIDTH_DEF,
  parameter int unsigned NUM_DEV = sreg_pkg::SREG_DEVS_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_in,
  input  logic                       shift_en,
  input  logic                       latch_en,
  input  logic                       sr_clr_n,
  input  logic                       oe_n,
  output logic [NUM_DEV*WIDTH-1:0]   par_q,
  output logic [NUM_DEV*WIDTH-1:0]   par_oe,
  output logic                       ser_out
);
  localparam int unsigned TOTAL = NUM_DEV * WIDTH;

  logic sr_arst_n;
  logic sr_rst_n;
  logic st_rst_n;
  logic [NUM_DEV:0] link;

  assign sr_arst_n = rst_n & sr_clr_n;

  sreg_rst_sync sr_sync_i (
    .clk    (clk),
    .arst_n (sr_arst_n),
    .srst_n (sr_rst_n)
  );

  sreg_rst_sync st_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (st_rst_n)
  );

  assign link[0] = ser_in;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    sreg_cell #(.WIDTH(WIDTH)) cell_i (
      .clk      (clk),
      .sr_rst_n (sr_rst_n),
      .st_rst_n (st_rst_n),
      .shift_en (shift_en),
      .latch_en (latch_en),
      .din      (link[k]),
      .oe_n     (oe_n),
      .par_q    (par_q[k*WIDTH +: WIDTH]),
      .par_oe   (par_oe[k*WIDTH +: WIDTH]),
      .dout     (link[k+1])
    );
  end

  assign ser_out = link[NUM_DEV];

  // R4
  oe_polarity_chk: assert property (@(posedge clk)
    (oe_n |-> (par_oe == '0)) and (!oe_n |-> (par_oe == {TOTAL{1'b1}})));
endmodule

// File: tb/sreg_chain_tb.sv
`timescale 1ns/1ps
module sreg_chain_tb_top;
  localparam int unsigned W  = 8;
  localparam int unsigned ND = 2;
  localparam int unsigned N  = W * ND;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n, ser_in, shift_en, latch_en, sr_clr_n, oe_n;
  logic [N-1:0] par_q, par_oe;
  logic ser_out;

  always #2 clk = ~clk;

  sreg_chain #(.WIDTH(W), .NUM_DEV(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .latch_en(latch_en), .sr_clr_n(sr_clr_n), .oe_n(oe_n),
    .par_q(par_q), .par_oe(par_oe), .ser_out(ser_out)
  );

  // Behavioural reference: one long shift vector and one storage vector.
  logic [N-1:0] m_sr, m_st;
  int sh_hold, st_hold;
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always @(posedge clk) begin
    logic [N-1:0] pre;
    pre = m_sr;
    if (!rst_n || !sr_clr_n) begin
      m_sr = '0; sh_hold = 2;
    end else if (sh_hold > 0) sh_hold = sh_hold - 1;
    else if (shift_en) m_sr = {m_sr[N-2:0], ser_in};
    if (!rst_n) begin
      m_st = '0; st_hold = 2;
    end else if (st_hold > 0) st_hold = st_hold - 1;
    else if (latch_en) m_st = pre;
  end

  task automatic check_all(input string tag);
    logic [N-1:0] exp_oe;
    exp_oe = oe_n ? '0 : '1;
    vectors++;
    if (par_q !== m_st || par_oe !== exp_oe || ser_out !== m_sr[N-1]) begin
      errors++;
      $display("FAIL %s par_q=%h/%h par_oe=%h/%h ser_out=%b/%b (actual/expected)",
               tag, par_q, m_st, par_oe, exp_oe, ser_out, m_sr[N-1]);
    end
  endtask

  // Called at a falling edge: drive, run one rising edge, check at next fall.
  task automatic step(input logic r, input logic c, input logic d,
                      input logic s, input logic l, input logic o,
                      input string tag);
    rst_n = r; sr_clr_n = c; ser_in = d; shift_en = s; latch_en = l; oe_n = o;
    if (!r || !c) begin m_sr = '0; sh_hold = 2; end
    if (!r) begin m_st = '0; st_hold = 2; end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] pat;
    m_sr = '0; m_st = '0; sh_hold = 2; st_hold = 2;
    @(negedge clk);
    // R10: reset clears everything, strobes right after release discarded
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 0, 0, 0, 0, "R6");
    // R1 / R7: shift a pattern, outputs must not move
    pat = 16'hA5C3;
    for (int i = N - 1; i >= 0; i--) step(1, 1, pat[i], 1, 0, 0, "R7");
    // R2: transfer
    step(1, 1, 0, 0, 1, 0, "R2");
    step(1, 1, 1, 0, 0, 0, "R6");
    // R4 / R5: disable outputs, keep shifting
    for (int i = 0; i < 5; i++) step(1, 1, i[0], 1, 0, 1, "R5");
    step(1, 1, 0, 0, 1, 1, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    // R8: shift and latch on the same edge
    step(1, 1, 1, 1, 1, 0, "R8");
    step(1, 1, 0, 1, 1, 0, "R8");
    // R3: clear mid-stream, storage untouched, early shifts discarded
    step(1, 0, 1, 1, 0, 0, "R3");
    step(1, 0, 1, 1, 0, 0, "R3");
    step(1, 1, 1, 1, 0, 0, "R3");
    step(1, 1, 1, 1, 0, 0, "R3");
    step(1, 1, 1, 1, 0, 0, "R3");
    step(1, 1, 0, 0, 1, 0, "R3");
    // R9 / R1: walk one bit through both devices
    step(1, 1, 1, 1, 0, 0, "R1");
    for (int i = 0; i < N; i++) step(1, 1, 0, 1, (i % 3 == 0), 0, "R9");
    // R10 again, latch tried right after release
    step(1, 1, 1, 1, 1, 0, "R10");
    step(0, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 1, 1, 1, 0, "R10");
    step(1, 1, 1, 1, 1, 0, "R10");
    // R6: random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned rv;
      rv = $urandom;
      step(1, (rv[7:0] != 8'd0), rv[8], rv[9], (rv[12:10] == 3'd0),
           (rv[15:13] == 3'd0), "R6");
    end
    finish_run();
  end
endmodule